// File: doc/BRIEF.md
# Firmware Trap Fetch Redirect Unit

This unit sits between the decode stage and instruction fetch of an in-order pipeline. It owns the fetch program counter and chooses where each fetch comes from: the application instruction memory or a separate firmware memory that the operating system controls. In normal operation the counter steps through application code one instruction at a time. When decode presents the one opcode reserved for entering the runtime, the unit drops the younger instruction already fetched and stops fetching. It then stores the caller's stack pointer and frame pointer into the header of the virtual-processor record. The register file supplies the address of that record. Once both stores are acknowledged, fetch resumes from the firmware entry address.

The address of the instruction after the switch is held inside the unit. A return opcode, decoded while in firmware, drops one younger fetch and resumes application fetch at that held address. The whole exchange costs one squashed slot plus the two store handshakes, about the price of a call. Any other argument, such as a pointer to the construct's data structure, stays in the register file for the firmware to read.

Top module: `fetch_redirect`

## Requirements
- R1: While reset is held, fetch_req_o is 1, fetch_fw_o is 0, fetch_pc_o equals RESET_PC (0), and squash_o, mem_wr_req_o and err_o are 0.
- R2: In a cycle with fetch_req_o high and squash_o low, the next cycle fetches from fetch_pc_o + 4 from the same source.
- R3: A valid decode opcode of 7'h0B (switch) in application mode raises squash_o in that same cycle, and fetch_req_o is low in the following cycle.
- R4: The first store after a switch has mem_wr_addr_o = record pointer + 0 and mem_wr_data_o = stack pointer. Request, address and data hold until mem_wr_ack_i.
- R5: After the first acknowledge, the second store has address record pointer + 4 and data = frame pointer, and it holds until acknowledged.
- R6: No fetch is requested while a store is pending. In the cycle after the second acknowledge, fetch_req_o = 1, fetch_fw_o = 1 and fetch_pc_o = FW_ENTRY.
- R7: A valid decode opcode of 7'h2B (return) in firmware mode raises squash_o in that cycle. The next cycle fetches from the application source at the switch's PC + 4.
- R8: A switch opcode decoded in firmware mode causes no squash and no store, and fetch continues sequentially in firmware. err_o goes to 1 and stays at 1 until reset.
- R9: A return opcode decoded in application mode has no effect: no squash, and fetch continues sequentially from the application source.
- R10: fetch_instr_o carries fw_rdata_i when fetch_fw_o is 1 and app_rdata_i when it is 0.
- R11: Decode inputs presented while the stores are pending are ignored.
- R12: The stored stack pointer, frame pointer and record pointer are the values present in the switch cycle, even if those inputs change afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decode slot holds a valid instruction |
| dec_opc_i | input | 7 | Opcode field of the decoded instruction |
| dec_pc_i | input | 32 | PC of the decoded instruction |
| sp_i | input | 32 | Current stack pointer |
| fp_i | input | 32 | Current frame pointer |
| vp_ptr_i | input | 32 | Register holding the virtual-processor record address |
| fetch_req_o | output | 1 | Fetch this cycle |
| fetch_fw_o | output | 1 | Fetch source: 1 = firmware memory, 0 = application memory |
| fetch_pc_o | output | 32 | Fetch address |
| app_rdata_i | input | 32 | Application memory read data |
| fw_rdata_i | input | 32 | Firmware memory read data |
| fetch_instr_o | output | 32 | Selected instruction word |
| squash_o | output | 1 | Drop the instruction fetched this cycle |
| mem_wr_req_o | output | 1 | Record store request |
| mem_wr_addr_o | output | 32 | Record store address |
| mem_wr_data_o | output | 32 | Record store data |
| mem_wr_ack_i | input | 1 | Record store accepted |
| err_o | output | 1 | Sticky: switch seen while already in firmware |

## Verification
On every cycle the assertions check that fetch steps sequentially, that a pending store holds its address and data until it is acknowledged, and that no fetch overlaps a store. They also check that a switch stalls fetch with a store under way, that a return lands back in application mode, and that the error flag stays set. Only the bench scenarios can show the rest: the exact record addresses and the captured pointer values after the inputs have moved, the firmware entry address, the return target, and the mux output and opcode decode across varied inputs.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int unsigned OPC_W = 7;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_SAVE_SP = 2'd1,
    ST_SAVE_FP = 2'd2
  } fr_state_e;
endpackage

// File: rtl/fr_decode.sv
module fr_decode #(
  parameter int unsigned OPC_W = 7,
  parameter logic [OPC_W-1:0] SW_OPC  = 7'h0B,
  parameter logic [OPC_W-1:0] RET_OPC = 7'h2B
) (
  input  logic             valid_i,
  input  logic [OPC_W-1:0] opc_i,
  input  logic             run_i,
  input  logic             fw_mode_i,
  output logic             sw_go_o,
  output logic             ret_go_o,
  output logic             sw_err_o
);
  logic live, is_sw, is_ret;

  assign live   = valid_i && run_i;
  assign is_sw  = live && (opc_i == SW_OPC);
  assign is_ret = live && (opc_i == RET_OPC);

  assign sw_go_o  = is_sw && !fw_mode_i;
  assign sw_err_o = is_sw && fw_mode_i;
  assign ret_go_o = is_ret && fw_mode_i;
endmodule

// File: rtl/fr_save.sv
module fr_save
  import fr_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned SP_OFS = 0,
  parameter int unsigned FP_OFS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] fp_i,
  input  logic [AW-1:0] vp_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [AW-1:0] SP_OFS_A = AW'(SP_OFS);
  localparam logic [AW-1:0] FP_OFS_A = AW'(FP_OFS);

  fr_state_e     st_q, st_d;
  logic [DW-1:0] sp_q, fp_q;
  logic [AW-1:0] vp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_RUN;
      sp_q <= '0;
      fp_q <= '0;
      vp_q <= '0;
    end else begin
      st_q <= st_d;
      if (start_i) begin
        sp_q <= sp_i;
        fp_q <= fp_i;
        vp_q <= vp_i;
      end
    end
  end

  always_comb begin
    st_d   = st_q;
    done_o = 1'b0;
    unique case (st_q)
      ST_RUN:     if (start_i) st_d = ST_SAVE_SP;
      ST_SAVE_SP: if (ack_i)   st_d = ST_SAVE_FP;
      ST_SAVE_FP: if (ack_i) begin
                    st_d   = ST_RUN;
                    done_o = 1'b1;
                  end
      default:    st_d = ST_RUN;
    endcase
  end

  assign busy_o = (st_q != ST_RUN);
  assign req_o  = busy_o;
  assign addr_o = vp_q + ((st_q == ST_SAVE_FP) ? FP_OFS_A : SP_OFS_A);
  assign data_o = (st_q == ST_SAVE_FP) ? fp_q : sp_q;
endmodule

// File: rtl/fr_pc.sv
module fr_pc #(
  parameter int unsigned   AW       = 32,
  parameter int unsigned   ILEN     = 4,
  parameter logic [AW-1:0] RESET_PC = '0,
  parameter logic [AW-1:0] FW_ENTRY = 32'h0000_8000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          sw_go_i,
  input  logic          ret_go_i,
  input  logic          save_done_i,
  input  logic [AW-1:0] dec_pc_i,
  output logic [AW-1:0] pc_o,
  output logic          fw_mode_o
);
  localparam logic [AW-1:0] STEP = AW'(ILEN);

  logic [AW-1:0] pc_q, ret_q;
  logic          fw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= RESET_PC;
      ret_q <= '0;
      fw_q  <= 1'b0;
    end else if (sw_go_i) begin
      ret_q <= dec_pc_i + STEP;     // pc_q frozen until stores finish
    end else if (save_done_i) begin
      pc_q  <= FW_ENTRY;
      fw_q  <= 1'b1;
    end else if (ret_go_i) begin
      pc_q  <= ret_q;
      fw_q  <= 1'b0;
    end else if (run_i) begin
      pc_q  <= pc_q + STEP;
    end
  end

  assign pc_o      = pc_q;
  assign fw_mode_o = fw_q;
endmodule

// File: rtl/fetch_redirect.sv
module fetch_redirect
  import fr_pkg::*;
#(
  parameter int unsigned   AW       = 32,
  parameter int unsigned   DW       = 32,
  parameter int unsigned   IW       = 32,
  parameter int unsigned   ILEN     = 4,
  parameter logic [AW-1:0] RESET_PC = '0,
  parameter logic [AW-1:0] FW_ENTRY = 32'h0000_8000,
  parameter logic [OPC_W-1:0] SW_OPC  = 7'h0B,
  parameter logic [OPC_W-1:0] RET_OPC = 7'h2B
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_valid_i,
  input  logic [OPC_W-1:0] dec_opc_i,
  input  logic [AW-1:0]    dec_pc_i,
  input  logic [DW-1:0]    sp_i,
  input  logic [DW-1:0]    fp_i,
  input  logic [AW-1:0]    vp_ptr_i,
  output logic             fetch_req_o,
  output logic             fetch_fw_o,
  output logic [AW-1:0]    fetch_pc_o,
  input  logic [IW-1:0]    app_rdata_i,
  input  logic [IW-1:0]    fw_rdata_i,
  output logic [IW-1:0]    fetch_instr_o,
  output logic             squash_o,
  output logic             mem_wr_req_o,
  output logic [AW-1:0]    mem_wr_addr_o,
  output logic [DW-1:0]    mem_wr_data_o,
  input  logic             mem_wr_ack_i,
  output logic             err_o
);
  localparam int unsigned SP_OFS = 0;
  localparam int unsigned FP_OFS = DW / 8;

  logic busy, run, fw_mode, sw_go, ret_go, sw_err, save_done, err_q;

  assign run = !busy;

  fr_decode #(
    .OPC_W   (OPC_W),
    .SW_OPC  (SW_OPC),
    .RET_OPC (RET_OPC)
  ) i_dec (
    .valid_i   (dec_valid_i),
    .opc_i     (dec_opc_i),
    .run_i     (run),
    .fw_mode_i (fw_mode),
    .sw_go_o   (sw_go),
    .ret_go_o  (ret_go),
    .sw_err_o  (sw_err)
  );

  fr_save #(
    .AW     (AW),
    .DW     (DW),
    .SP_OFS (SP_OFS),
    .FP_OFS (FP_OFS)
  ) i_save (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sw_go),
    .sp_i    (sp_i),
    .fp_i    (fp_i),
    .vp_i    (vp_ptr_i),
    .ack_i   (mem_wr_ack_i),
    .req_o   (mem_wr_req_o),
    .addr_o  (mem_wr_addr_o),
    .data_o  (mem_wr_data_o),
    .busy_o  (busy),
    .done_o  (save_done)
  );

  fr_pc #(
    .AW       (AW),
    .ILEN     (ILEN),
    .RESET_PC (RESET_PC),
    .FW_ENTRY (FW_ENTRY)
  ) i_pc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .sw_go_i     (sw_go),
    .ret_go_i    (ret_go),
    .save_done_i (save_done),
    .dec_pc_i    (dec_pc_i),
    .pc_o        (fetch_pc_o),
    .fw_mode_o   (fw_mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= 1'b0;
    else if (sw_err) err_q <= 1'b1;
  end

  assign fetch_req_o   = run;
  assign fetch_fw_o    = fw_mode;
  assign squash_o      = sw_go || ret_go;
  assign err_o         = err_q;
  assign fetch_instr_o = fw_mode ? fw_rdata_i : app_rdata_i;
endmodule

// File: rtl/fetch_redirect_chk.sv
module fetch_redirect_chk #(
  parameter int unsigned AW   = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned ILEN = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fetch_req_o,
  input logic          fetch_fw_o,
  input logic [AW-1:0] fetch_pc_o,
  input logic          squash_o,
  input logic          mem_wr_req_o,
  input logic [AW-1:0] mem_wr_addr_o,
  input logic [DW-1:0] mem_wr_data_o,
  input logic          mem_wr_ack_i,
  input logic          err_o
);
  p_seq_fetch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && !squash_o) |=>
      (fetch_req_o && fetch_pc_o == $past(fetch_pc_o) + AW'(ILEN)
       && fetch_fw_o == $past(fetch_fw_o)));

  p_switch_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squash_o && !fetch_fw_o) |=> (!fetch_req_o && mem_wr_req_o));

  p_store_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_req_o && !mem_wr_ack_i) |=>
      (mem_wr_req_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o)));

  p_no_fetch_in_save_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_req_o |-> !fetch_req_o);

  p_return_app_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squash_o && fetch_fw_o) |=> (fetch_req_o && !fetch_fw_o));

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind fetch_redirect fetch_redirect_chk #(.AW(AW), .DW(DW), .ILEN(ILEN)) i_chk (.*);

// File: tb/test_fetch_redirect.sv
`timescale 1ns/1ps
module test_fetch_redirect;
  localparam logic [31:0] ENTRY = 32'h0000_8000;
  localparam logic [6:0]  SW    = 7'h0B;
  localparam logic [6:0]  RET   = 7'h2B;
  localparam int NV = 6;
  // {opcode, app read data}; none may enter firmware from app mode
  localparam logic [38:0] VEC [NV] = '{
    {7'h33, 32'h0000_0033},
    {RET,   32'h1234_5678},
    {7'h13, 32'hDEAD_BEEF},
    {7'h0A, 32'h0F0F_0F0F},
    {7'h0C, 32'hA5A5_5A5A},
    {RET,   32'hFFFF_0000}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_ni, dec_valid, fetch_req, fetch_fw, squash, wr_req, wr_ack, err;
  logic [6:0]  dec_opc;
  logic [31:0] dec_pc, sp, fp, vp, fetch_pc, app_rd, fw_rd, instr, wr_addr, wr_data;

  fetch_redirect i_fetch_redirect (
    .clk_i(clk), .rst_ni(rst_ni), .dec_valid_i(dec_valid), .dec_opc_i(dec_opc),
    .dec_pc_i(dec_pc), .sp_i(sp), .fp_i(fp), .vp_ptr_i(vp),
    .fetch_req_o(fetch_req), .fetch_fw_o(fetch_fw), .fetch_pc_o(fetch_pc),
    .app_rdata_i(app_rd), .fw_rdata_i(fw_rd), .fetch_instr_o(instr),
    .squash_o(squash), .mem_wr_req_o(wr_req), .mem_wr_addr_o(wr_addr),
    .mem_wr_data_o(wr_data), .mem_wr_ack_i(wr_ack), .err_o(err)
  );

  int  n_chk = 0, n_fail = 0;
  bit  done  = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog all act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_pc, sw_pc;
    rst_ni = 1'b0; dec_valid = 1'b0; dec_opc = '0; dec_pc = '0;
    sp = '0; fp = '0; vp = '0; app_rd = '0; fw_rd = '0; wr_ack = 1'b0;
    @(negedge clk); #1;
    chk("R1 fetch_req", 32'(fetch_req), 32'd1);
    chk("R1 fetch_fw",  32'(fetch_fw),  32'd0);
    chk("R1 fetch_pc",  fetch_pc,       32'd0);
    chk("R1 squash/req/err", {29'd0, squash, wr_req, err}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    exp_pc = 32'd0;

    for (int i = 0; i < NV; i++) begin
      dec_valid = 1'b1;
      dec_opc   = VEC[i][38:32];
      dec_pc    = exp_pc - 32'd4;
      app_rd    = VEC[i][31:0];
      fw_rd     = ~VEC[i][31:0];
      #1;
      chk("R9 no squash in app mode", 32'(squash), 32'd0);
      chk("R10 app instr selected", instr, VEC[i][31:0]);
      chk("R2 sequential pc", fetch_pc, exp_pc);
      chk("R9 stays app", {30'd0, fetch_fw, err}, 32'd0);
      tick();
      exp_pc = exp_pc + 32'd4;
    end

    // switch to runtime
    sw_pc = exp_pc - 32'd4;
    dec_valid = 1'b1; dec_opc = SW; dec_pc = sw_pc;
    sp = 32'h1000_0F00; fp = 32'h1000_0F40; vp = 32'h2000_0100;
    #1;
    chk("R3 squash on switch", 32'(squash), 32'd1);
    tick();
    dec_opc = RET;   // must be ignored (R11)
    sp = 32'hBAD0_0001; fp = 32'hBAD0_0002; vp = 32'hBAD0_0003;
    #1;
    chk("R3 fetch stalled", 32'(fetch_req), 32'd0);
    chk("R4 first store req", 32'(wr_req), 32'd1);
    chk("R4 sp store addr", wr_addr, 32'h2000_0100);
    chk("R12 captured sp", wr_data, 32'h1000_0F00);
    tick(); #1;
    chk("R4 sp store held addr", wr_addr, 32'h2000_0100);
    chk("R4 sp store held data", wr_data, 32'h1000_0F00);
    wr_ack = 1'b1;
    tick();
    wr_ack = 1'b0; #1;
    chk("R5 fp store addr", wr_addr, 32'h2000_0104);
    chk("R12 captured fp", wr_data, 32'h1000_0F40);
    chk("R6 no fetch while storing", 32'(fetch_req), 32'd0);
    tick(); #1;
    chk("R5 fp store held", wr_addr, 32'h2000_0104);
    chk("R11 decode ignored during save", {30'd0, squash, fetch_fw}, 32'd0);
    wr_ack = 1'b1;
    tick();
    wr_ack = 1'b0; dec_valid = 1'b0;
    fw_rd = 32'h0BAD_F00D; app_rd = 32'h1111_2222; #1;
    chk("R6 store done", 32'(wr_req), 32'd0);
    chk("R6 firmware fetch", {30'd0, fetch_req, fetch_fw}, 32'd3);
    chk("R6 entry pc", fetch_pc, ENTRY);
    chk("R10 fw instr selected", instr, 32'h0BAD_F00D);
    exp_pc = ENTRY;
    tick(); #1;
    exp_pc = exp_pc + 32'd4;
    chk("R2 firmware sequential", fetch_pc, exp_pc);

    // nested switch in firmware
    dec_valid = 1'b1; dec_opc = SW; dec_pc = exp_pc - 32'd4; #1;
    chk("R8 no squash nested switch", 32'(squash), 32'd0);
    tick();
    dec_valid = 1'b0; #1;
    exp_pc = exp_pc + 32'd4;
    chk("R8 err set", 32'(err), 32'd1);
    chk("R8 fetch continues", fetch_pc, exp_pc);
    chk("R8 still firmware, no store", {30'd0, fetch_fw, wr_req}, 32'd2);

    // return to application
    dec_valid = 1'b1; dec_opc = RET; dec_pc = exp_pc - 32'd4; #1;
    chk("R7 squash on return", 32'(squash), 32'd1);
    tick();
    dec_valid = 1'b0; #1;
    chk("R7 app mode", 32'(fetch_fw), 32'd0);
    chk("R7 return pc", fetch_pc, sw_pc + 32'd4);
    chk("R8 err sticky", 32'(err), 32'd1);
    tick(); #1;
    chk("R2 app sequential after return", fetch_pc, sw_pc + 32'd8);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule